// File: doc/BRIEF.md
# Timed Strobe Configuration Loader

This block moves a multi-byte configuration word into an external converter through a byte-wide data bus and three strobe lines. The converter needs the strobes to change in a fixed order, and each change must follow the previous one by a minimum time in nanoseconds. A single start pulse latches the whole word. The block then presents one byte at a time, most significant byte first, and runs the strobe sequence for each byte. When the last byte has been transferred, it raises a one-cycle done pulse.

All timing is derived from clock cycles. Parameters give the system clock period in picoseconds and each minimum delay in nanoseconds. Every wait becomes the ceiling of delay divided by period, and never less than one cycle. If the design is retargeted to a different clock rate, changing the period parameter keeps every spacing legal.

Per byte, the sequence runs as follows:
1. The byte is placed on the bus and allowed to settle.
2. The write strobe falls.
3. Control strobe A rises.
4. Control strobe B falls.
5. After a hold time, all three strobes return to idle together.
6. The bus stays unchanged for one more hold time.

Top module: `strobe_cfg_loader`

## Requirements
- R1: After a synchronous reset, the idle levels are: write strobe high, control strobe A low, control strobe B high, done low.
- R2: Within each byte, the write strobe falls first, then A rises, then B falls. Afterwards all three return to their idle levels on the same clock edge.
- R3: The spacing from the write strobe falling to A rising is at least GAP1 cycles, where GAP1 = max(1, ceil(GAP1_NS*1000/CLK_PERIOD_PS)).
- R4: The spacing from A rising to B falling is at least GAP2 cycles, computed the same way from GAP2_NS.
- R5: The data byte changes only while all strobes are idle. It is driven SETUP cycles (from SETUP_NS) before the write strobe falls. It stays stable for HOLD cycles (from HOLD_NS) after the strobes return to idle.
- R6: A transfer sends exactly NBYTES bytes of cfg_i. Byte k is cfg_i[NBYTES*8-1-8k -: 8], so the most significant byte goes first.
- R7: HOLD cycles after the last byte's strobes return to idle, done_o is high for exactly one cycle. During that cycle the strobes are at their idle levels.
- R8: start_i is ignored while a transfer is in progress, including any new cfg_i value presented with it.
- R9: Reset during a transfer immediately restores the idle levels and clears the byte count. The next start therefore begins again from the most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled only when idle |
| cfg_i | input | NBYTES*8 | Configuration word, latched on accepted start |
| data_o | output | 8 | Byte presented to the converter |
| wr_strobe_o | output | 1 | Write strobe, idle high |
| ctl_a_o | output | 1 | Control strobe A, idle low |
| ctl_b_o | output | 1 | Control strobe B, idle high |
| done_o | output | 1 | One-cycle pulse when all bytes are sent |

## Verification
Some properties are checked on every clock cycle:
- the order of strobe edges;
- the minimum cycle counts between the write-strobe fall and A rising, and between A rising and B falling, measured by age counters in the checker;
- data stability while any strobe is active;
- done being a single idle-level cycle.

Other behaviour only the bench scenarios can show:
- the exact position of each edge within the per-byte frame;
- byte order across the word;
- that a start during a transfer leaves the word unchanged;
- that reset mid-transfer makes the next transfer restart from the first byte.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WR_LOW,
    ST_A_HIGH,
    ST_B_LOW,
    ST_HOLD
  } sgs_state_t;

  // Minimum delay in ns to a cycle count, rounded up, at least one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sgs_gap_timer.sv
module sgs_gap_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sgs_byte_shift.sv
module sgs_byte_shift #(
  parameter int NBYTES = 5,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   shift,
  input  logic [NBYTES*BYTE_W-1:0] word_i,
  output logic [BYTE_W-1:0]      byte_o,
  output logic                   last_o
);
  localparam int WW = NBYTES * BYTE_W;
  localparam int IW = $clog2(NBYTES + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

  logic [WW-1:0] sreg;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= word_i;
      idx  <= '0;
    end else if (shift) begin
      sreg <= sreg << BYTE_W;
      idx  <= idx + 1'b1;
    end
  end

  assign byte_o = sreg[WW-1 -: BYTE_W];
  assign last_o = (idx == LAST_IDX);
endmodule

// File: rtl/sgs_seq_fsm.sv
module sgs_seq_fsm
  import sgs_pkg::*;
#(
  parameter int TW     = 4,
  parameter int SU_CYC = 1,
  parameter int G1_CYC = 1,
  parameter int G2_CYC = 1,
  parameter int HD_CYC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          tmr_expired,
  input  logic          last_byte,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          word_load,
  output logic          word_shift,
  output logic          wr_strobe_o,
  output logic          ctl_a_o,
  output logic          ctl_b_o,
  output logic          done_o
);
  localparam logic [TW-1:0] SU_LD = TW'(SU_CYC - 1);
  localparam logic [TW-1:0] G1_LD = TW'(G1_CYC - 1);
  localparam logic [TW-1:0] G2_LD = TW'(G2_CYC - 1);
  localparam logic [TW-1:0] HD_LD = TW'(HD_CYC - 1);

  sgs_state_t state;

  always_comb begin
    tmr_load   = 1'b0;
    tmr_val    = '0;
    word_load  = 1'b0;
    word_shift = 1'b0;
    unique case (state)
      ST_IDLE:   if (start_i)     begin tmr_load = 1'b1; tmr_val = SU_LD; word_load = 1'b1; end
      ST_SETUP:  if (tmr_expired) begin tmr_load = 1'b1; tmr_val = G1_LD; end
      ST_WR_LOW: if (tmr_expired) begin tmr_load = 1'b1; tmr_val = G2_LD; end
      ST_A_HIGH: if (tmr_expired) begin tmr_load = 1'b1; tmr_val = HD_LD; end
      ST_B_LOW:  if (tmr_expired) begin tmr_load = 1'b1; tmr_val = HD_LD; end
      ST_HOLD:   if (tmr_expired && !last_byte) begin
                   tmr_load = 1'b1; tmr_val = SU_LD; word_shift = 1'b1;
                 end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      wr_strobe_o <= 1'b1;
      ctl_a_o     <= 1'b0;
      ctl_b_o     <= 1'b1;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE:   if (start_i) state <= ST_SETUP;
        ST_SETUP:  if (tmr_expired) begin wr_strobe_o <= 1'b0; state <= ST_WR_LOW; end
        ST_WR_LOW: if (tmr_expired) begin ctl_a_o <= 1'b1; state <= ST_A_HIGH; end
        ST_A_HIGH: if (tmr_expired) begin ctl_b_o <= 1'b0; state <= ST_B_LOW; end
        ST_B_LOW:  if (tmr_expired) begin
                     wr_strobe_o <= 1'b1;
                     ctl_a_o     <= 1'b0;
                     ctl_b_o     <= 1'b1;
                     state       <= ST_HOLD;
                   end
        ST_HOLD:   if (tmr_expired) begin
                     if (last_byte) begin done_o <= 1'b1; state <= ST_IDLE; end
                     else state <= ST_SETUP;
                   end
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strobe_cfg_loader.sv
module strobe_cfg_loader
  import sgs_pkg::*;
#(
  parameter int NBYTES        = 5,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int GAP1_NS       = 5,
  parameter int GAP2_NS       = 4,
  parameter int SETUP_NS      = 10,
  parameter int HOLD_NS       = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [NBYTES*8-1:0] cfg_i,
  output logic [7:0]          data_o,
  output logic                wr_strobe_o,
  output logic                ctl_a_o,
  output logic                ctl_b_o,
  output logic                done_o
);
  localparam int SU_CYC   = int'(ns_to_cyc(SETUP_NS, CLK_PERIOD_PS));
  localparam int GAP1_CYC = int'(ns_to_cyc(GAP1_NS, CLK_PERIOD_PS));
  localparam int GAP2_CYC = int'(ns_to_cyc(GAP2_NS, CLK_PERIOD_PS));
  localparam int HD_CYC   = int'(ns_to_cyc(HOLD_NS, CLK_PERIOD_PS));
  localparam int MAX_CYC  = int'(max4(SU_CYC, GAP1_CYC, GAP2_CYC, HD_CYC));
  localparam int TW       = $clog2(MAX_CYC + 1);

  logic          tmr_load, tmr_expired, word_load, word_shift, last_byte;
  logic [TW-1:0] tmr_val;

  sgs_gap_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sgs_byte_shift #(.NBYTES(NBYTES), .BYTE_W(8)) shift_i (
    .clk(clk), .rst(rst), .load(word_load), .shift(word_shift),
    .word_i(cfg_i), .byte_o(data_o), .last_o(last_byte)
  );

  sgs_seq_fsm #(
    .TW(TW), .SU_CYC(SU_CYC), .G1_CYC(GAP1_CYC), .G2_CYC(GAP2_CYC), .HD_CYC(HD_CYC)
  ) fsm_i (
    .clk(clk), .rst(rst), .start_i(start_i), .tmr_expired(tmr_expired),
    .last_byte(last_byte), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .word_load(word_load), .word_shift(word_shift),
    .wr_strobe_o(wr_strobe_o), .ctl_a_o(ctl_a_o), .ctl_b_o(ctl_b_o), .done_o(done_o)
  );
endmodule

// File: rtl/strobe_cfg_loader_chk.sv
module strobe_cfg_loader_chk #(
  parameter int G1_CYC = 1,
  parameter int G2_CYC = 1
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] data_o,
  input logic       wr_strobe_o,
  input logic       ctl_a_o,
  input logic       ctl_b_o,
  input logic       done_o
);
  logic [7:0] wr_age, a_age;

  always_ff @(posedge clk) begin
    if (rst || wr_strobe_o) wr_age <= '0;
    else if (wr_age != 8'hFF) wr_age <= wr_age + 1'b1;
    if (rst || !ctl_a_o) a_age <= '0;
    else if (a_age != 8'hFF) a_age <= a_age + 1'b1;
  end

  AST_A_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_a_o) |-> !wr_strobe_o); // R2
  AST_B_AFTER_A: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_b_o) |-> (ctl_a_o && !wr_strobe_o)); // R2
  AST_GAP_WR_TO_A: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_a_o) |-> (32'(wr_age) >= G1_CYC)); // R3
  AST_GAP_A_TO_B: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_b_o) |-> (32'(a_age) >= G2_CYC)); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (!wr_strobe_o || ctl_a_o || !ctl_b_o) |-> $stable(data_o)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (wr_strobe_o && !ctl_a_o && ctl_b_o)); // R7
endmodule

bind strobe_cfg_loader strobe_cfg_loader_chk #(.G1_CYC(GAP1_CYC), .G2_CYC(GAP2_CYC)) chk_i (
  .clk(clk), .rst(rst), .data_o(data_o), .wr_strobe_o(wr_strobe_o),
  .ctl_a_o(ctl_a_o), .ctl_b_o(ctl_b_o), .done_o(done_o)
);

// File: tb/strobe_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module strobe_cfg_loader_tb_top;
  localparam int NB = 5;
  // Bench parameters at 5 ns period: SETUP 1, GAP1 3, GAP2 1, HOLD 2 cycles -> 9-cycle frame per byte.
  localparam int FRAME = 9;
  // Expected {wr, a, b} at phase p after the frame's first edge.
  localparam logic [2:0] PHASE_TAB [0:8] = '{3'b101, 3'b001, 3'b001, 3'b001,
                                              3'b011, 3'b010, 3'b010, 3'b101, 3'b101};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [NB*8-1:0] cfg_i = '0;
  logic [7:0] data_o;
  logic wr_strobe_o, ctl_a_o, ctl_b_o, done_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  strobe_cfg_loader #(
    .NBYTES(NB), .CLK_PERIOD_PS(5000), .GAP1_NS(12), .GAP2_NS(4), .SETUP_NS(5), .HOLD_NS(8)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_i), .data_o(data_o),
    .wr_strobe_o(wr_strobe_o), .ctl_a_o(ctl_a_o), .ctl_b_o(ctl_b_o), .done_o(done_o)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({wr_strobe_o, ctl_a_o, ctl_b_o, done_o} == 4'b1010, req,
        16'({wr_strobe_o, ctl_a_o, ctl_b_o, done_o}), 16'h000A);
  endtask

  // One full transfer; optionally present a different word with start mid-transfer (R8)
  // or stop after abort_at samples (abort_at < 0 runs to completion).
  task automatic run_seq(input logic [NB*8-1:0] cfg, input bit inject, input int abort_at);
    @(negedge clk);
    cfg_i = cfg; start_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k < NB*FRAME; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (inject && k == 3)  begin start_i = 1'b1; cfg_i = ~cfg; end
      if (inject && k == 20) begin start_i = 1'b1; cfg_i = 40'h0; end
      if (k == abort_at) return;
      begin
        int b = k / FRAME;
        int p = k % FRAME;
        logic [7:0] exp_b = cfg[NB*8-1-8*b -: 8];
        chk({wr_strobe_o, ctl_a_o, ctl_b_o} == PHASE_TAB[p], "R2/R3/R4 strobes",
            16'({wr_strobe_o, ctl_a_o, ctl_b_o}), 16'(PHASE_TAB[p]));
        chk(data_o == exp_b, inject ? "R8 data" : "R5/R6 data", 16'(data_o), 16'(exp_b));
        chk(done_o == 1'b0, "R7 early done", 16'(done_o), 16'h0);
      end
      @(posedge clk);
    end
    @(negedge clk);
    start_i = 1'b0;
    chk({wr_strobe_o, ctl_a_o, ctl_b_o, done_o} == 4'b1011, "R7 done pulse",
        16'({wr_strobe_o, ctl_a_o, ctl_b_o, done_o}), 16'h000B);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", 16'(done_o), 16'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 reset levels");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 idle after release");

    run_seq(40'h12_34_56_78_9A, 1'b0, -1);
    run_seq(40'hA5_5A_0F_F0_C3, 1'b1, -1);

    // R9: reset in the middle of the second byte.
    run_seq(40'hFF_EE_DD_CC_BB, 1'b0, 12);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R9 reset mid-transfer");
    rst = 1'b0;
    repeat (12) begin
      @(negedge clk);
      chk_idle("R9 stays idle");
    end
    run_seq(40'hDE_AD_BE_EF_01, 1'b0, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule